// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Controller

This block manages a two-bank endpoint buffer placed between a USB serial interface engine and a CPU. At any moment one bank belongs to the engine side and the other to the CPU side. When the producing side finishes a packet and the consuming side's bank is free, the banks swap in the same clock edge. On an OUT endpoint the engine produces and the CPU consumes. On an IN endpoint the CPU produces and the engine consumes.

A 16-bit command/status word gives the byte count held in the engine-side bank and a busy bit. The busy bit is set while a finished packet waits because the other bank is still occupied. Two command bits in that word let the CPU act on the engine-side bank. On an OUT endpoint in continuous mode, the toggle bit forces the engine-side bank to end reception. On an IN endpoint, the clear bit empties the engine-side bank. A second word holds a buffer-ready status that drives a level interrupt, a sticky command-error flag, and the CPU-side valid flag.

A forced toggle never discards packet data. If the CPU-side bank still holds unread bytes, the engine-side bank is marked finished and the swap waits until the CPU drains its bank. The ready interrupt is still raised at once.

Top module: `pingpong_ep_ctrl`

## Requirements
- R1: After reset, the status word (address 0) and the event word (address 1) both read 0, and `irq` is low.
- R2: On an OUT endpoint, each `sie_stb` byte is stored, and status bits [10:0] give the engine-side byte count. Bytes beyond DEPTH are dropped, so the count stops at DEPTH. Status bits [15:12] always read 0.
- R3: When `sie_eop` arrives and the CPU-side bank is empty, the banks swap at that edge. The engine-side count then reads 0, event bit 2 (CPU valid) reads 1, and event bit 0 (ready) and `irq` read 1. `cpu_rdata` presents the stored bytes in arrival order, advanced by `cpu_stb`. The read that consumes the last byte clears event bit 2.
- R4: When `sie_eop` arrives while the CPU-side bank is full, status bit 11 (busy) reads 1 and further engine bytes are dropped. The swap happens at the edge where the CPU reads its last byte.
- R5: Writing status bit 13 = 1 on an OUT endpoint, in continuous mode, with NAK set and busy clear, ends reception. With the CPU-side bank empty, this swaps the banks exactly as an end-of-packet does.
- R6: A forced toggle while the CPU-side bank holds unread data keeps that data readable and unchanged, sets busy, and raises ready/`irq`. The toggled packet becomes readable after the CPU drains its bank.
- R7: The following status writes are ignored and set sticky event bit 1 (error), which is cleared by writing 1 to it:
  - bit 13 on an IN endpoint or outside continuous mode;
  - bit 12 on an OUT endpoint;
  - either bit while NAK is off or busy is set.
  Writing 0 to both bits has no effect.
- R8: On an IN endpoint, `cpu_stb` stores CPU bytes and `cpu_eop` swaps them to the engine side when that bank is free. The status count then shows their number, and `sie_rdata` presents them in order, advanced by `sie_stb`. If the engine-side bank is still occupied, busy reads 1 until the engine consumes its last byte.
- R9: On an IN endpoint with NAK set and busy clear, writing status bit 12 = 1 empties the engine-side bank, so the count reads 0 at the next edge.
- R10: `irq` equals event bit 0. It stays high until the CPU writes 1 to event bit 0.
- R11: A zero-length packet still swaps and sets CPU valid. A single `cpu_stb` then clears CPU valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_cont | input | 1 | Continuous transfer mode enable |
| cfg_nak | input | 1 | Endpoint response currently NAK |
| sie_stb | input | 1 | Engine byte strobe (write on OUT, consume on IN) |
| sie_wdata | input | DW | Engine byte written on OUT |
| sie_eop | input | 1 | Engine end of received packet (OUT) |
| sie_rdata | output | DW | Next byte for the engine to send (IN) |
| cpu_stb | input | 1 | CPU byte strobe (consume on OUT, write on IN) |
| cpu_wdata | input | DW | CPU byte written on IN |
| cpu_eop | input | 1 | CPU end of packet to send (IN) |
| cpu_rdata | output | DW | Next byte for the CPU to read (OUT) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = event word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Buffer-ready interrupt, level |

## Verification
A wrong bank index or a stale full flag shows up as wrong bytes on `cpu_rdata` or `sie_rdata`, or as a status count that does not return to 0, on the first read after the swap edge. A lost pending packet shows as busy stuck at 1 after the consumer drains, visible one cycle after the last read. A mis-decoded command appears the cycle after the write, as either an unexpected swap (count, valid and `irq` change) or a missing error flag, so every command combination is checked on the next clock.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;

  localparam int STAT_CNT_W = 11;

  // status word: [15:12] zero, [11] busy, [10:0] engine-side count
  function automatic logic [15:0] stat_word(input logic busy,
                                            input logic [STAT_CNT_W-1:0] cnt);
    return {4'b0000, busy, cnt};
  endfunction

  // a command that must be refused
  function automatic logic cmd_bad(input logic tgl, input logic clr,
                                   input logic dir_in, input logic cont,
                                   input logic nak, input logic busy);
    return (tgl & (dir_in | ~cont)) | (clr & ~dir_in) |
           ((tgl | clr) & (busy | ~nak));
  endfunction

  // event word: [2] cpu valid, [1] error, [0] ready
  function automatic logic [15:0] evt_word(input logic valid, input logic err,
                                           input logic rdy);
    return {13'd0, valid, err, rdy};
  endfunction

endpackage

// File: rtl/pp_ep_mem.sv
module pp_ep_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [2][DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[wbank][waddr] <= wdata;
  end

  assign rdata = mem_q[rbank][raddr];

endmodule

// File: rtl/pp_ep_ctrl.sv
module pp_ep_ctrl #(
  parameter int DW     = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_in,
  input  logic             prod_wr,
  input  logic [DW-1:0]    prod_data,
  input  logic             prod_end,
  input  logic             cons_rd,
  input  logic             do_clr,
  output logic             prod_full,
  output logic             cons_full,
  output logic             swap_evt,
  output logic [CNT_W-1:0] sie_cnt,
  output logic [DW-1:0]    cons_data
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             bank_q;      // physical bank facing the engine
  logic             pfull_q, cfull_q;
  logic [CNT_W-1:0] len_q [2];
  logic [CNT_W-1:0] ptr_q [2];

  // named internal events
  logic pb, qb, wr_ok, q_last, step, drain, cfull_mid, pfull_mid, swap;

  assign pb        = dir_in ? ~bank_q : bank_q;   // producer bank
  assign qb        = ~pb;                         // consumer bank
  assign wr_ok     = prod_wr & ~pfull_q & (len_q[pb] < DEPTH_C);
  assign q_last    = (ptr_q[qb] + 1'b1) >= len_q[qb];
  assign step      = cons_rd & cfull_q & ~q_last;
  assign drain     = (cons_rd & cfull_q & q_last) | do_clr;
  assign cfull_mid = cfull_q & ~drain;
  assign pfull_mid = pfull_q | prod_end;
  assign swap      = pfull_mid & ~cfull_mid;

  pp_ep_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .wbank (pb),
    .waddr (len_q[pb][AW-1:0]),
    .wdata (prod_data),
    .rbank (qb),
    .raddr (ptr_q[qb][AW-1:0]),
    .rdata (cons_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      pfull_q <= 1'b0;
      cfull_q <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        len_q[b] <= '0;
        ptr_q[b] <= '0;
      end
    end else begin
      if (wr_ok) len_q[pb] <= len_q[pb] + 1'b1;
      if (step)  ptr_q[qb] <= ptr_q[qb] + 1'b1;
      if (drain) begin
        len_q[qb] <= '0;
        ptr_q[qb] <= '0;
      end
      cfull_q <= cfull_mid | swap;
      pfull_q <= pfull_mid & ~swap;
      if (swap) bank_q <= ~bank_q;
    end
  end

  assign prod_full = pfull_q;
  assign cons_full = cfull_q;
  assign swap_evt  = swap;
  assign sie_cnt   = len_q[bank_q];

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q[0] <= DEPTH_C) && (len_q[1] <= DEPTH_C));

  assert_swap_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> cfull_q);

  assert_keep_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfull_q && !cons_rd && !do_clr) |=> cfull_q);

  assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pfull_q && cfull_q && !cons_rd && !do_clr) |=> pfull_q);

endmodule

// File: rtl/pp_ep_regs.sv
module pp_ep_regs
  import pp_ep_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dir_in,
  input  logic                  cont,
  input  logic                  nak,
  input  logic                  busy,
  input  logic                  swap_evt,
  input  logic                  cpu_valid,
  input  logic [STAT_CNT_W-1:0] sie_cnt,
  input  logic                  reg_we,
  input  logic                  reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  output logic                  do_tgl,
  output logic                  do_clr,
  output logic                  irq
);

  logic rdy_q, err_q;
  logic wr_stat, wr_evt, tgl_w, clr_w, bad, rdy_ack, err_ack;
  logic unused_wbits;

  assign wr_stat = reg_we & ~reg_addr;
  assign wr_evt  = reg_we & reg_addr;
  assign tgl_w   = wr_stat & reg_wdata[13];
  assign clr_w   = wr_stat & reg_wdata[12];
  assign bad     = cmd_bad(tgl_w, clr_w, dir_in, cont, nak, busy);
  assign do_tgl  = tgl_w & ~bad;
  assign do_clr  = clr_w & ~bad;
  assign rdy_ack = wr_evt & reg_wdata[0];
  assign err_ack = wr_evt & reg_wdata[1];
  assign unused_wbits = ^{reg_wdata[15:14], reg_wdata[11:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rdy_q <= (rdy_q & ~rdy_ack) | swap_evt | do_tgl;
      err_q <= (err_q & ~err_ack) | bad;
    end
  end

  assign reg_rdata = reg_addr ? evt_word(cpu_valid, err_q, rdy_q)
                              : stat_word(busy, sie_cnt);
  assign irq = rdy_q;

  assert_bad_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_q);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_ack) |=> err_q);

  assert_tgl_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_tgl |=> irq);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rdy_ack) |=> irq);

endmodule

// File: rtl/pingpong_ep_ctrl.sv
module pingpong_ep_ctrl
  import pp_ep_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dir_in,
  input  logic          cfg_cont,
  input  logic          cfg_nak,
  input  logic          sie_stb,
  input  logic [DW-1:0] sie_wdata,
  input  logic          sie_eop,
  output logic [DW-1:0] sie_rdata,
  input  logic          cpu_stb,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_eop,
  output logic [DW-1:0] cpu_rdata,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq
);

  logic             do_tgl, do_clr, prod_full, cons_full, swap_evt;
  logic             prod_wr, prod_end, cons_rd, cpu_valid;
  logic [DW-1:0]    prod_data, cons_data;
  logic [CNT_W-1:0] sie_cnt;

  assign prod_wr   = cfg_dir_in ? cpu_stb   : sie_stb;
  assign prod_data = cfg_dir_in ? cpu_wdata : sie_wdata;
  assign prod_end  = cfg_dir_in ? cpu_eop   : (sie_eop | do_tgl);
  assign cons_rd   = cfg_dir_in ? sie_stb   : cpu_stb;
  assign cpu_valid = cfg_dir_in ? prod_full : cons_full;
  assign sie_rdata = cfg_dir_in ? cons_data : '0;
  assign cpu_rdata = cfg_dir_in ? '0 : cons_data;

  pp_ep_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_in    (cfg_dir_in),
    .prod_wr   (prod_wr),
    .prod_data (prod_data),
    .prod_end  (prod_end),
    .cons_rd   (cons_rd),
    .do_clr    (do_clr),
    .prod_full (prod_full),
    .cons_full (cons_full),
    .swap_evt  (swap_evt),
    .sie_cnt   (sie_cnt),
    .cons_data (cons_data)
  );

  pp_ep_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_in    (cfg_dir_in),
    .cont      (cfg_cont),
    .nak       (cfg_nak),
    .busy      (prod_full),
    .swap_evt  (swap_evt),
    .cpu_valid (cpu_valid),
    .sie_cnt   (STAT_CNT_W'(sie_cnt)),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .do_tgl    (do_tgl),
    .do_clr    (do_clr),
    .irq       (irq)
  );

  assert_busy_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prod_full |-> cons_full);

  assert_irq_on_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> irq);

endmodule

// File: tb/sim_pingpong_ep_ctrl.sv
module sim_pingpong_ep_ctrl;

  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dir_in = 1'b0, cfg_cont = 1'b1, cfg_nak = 1'b1;
  logic        sie_stb = 1'b0, sie_eop = 1'b0, cpu_stb = 1'b0, cpu_eop = 1'b0;
  logic [7:0]  sie_wdata = '0, cpu_wdata = '0;
  logic [7:0]  sie_rdata, cpu_rdata;
  logic        reg_we = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pingpong_ep_ctrl #(.DW(8), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_cont(cfg_cont),
    .cfg_nak(cfg_nak), .sie_stb(sie_stb), .sie_wdata(sie_wdata),
    .sie_eop(sie_eop), .sie_rdata(sie_rdata), .cpu_stb(cpu_stb),
    .cpu_wdata(cpu_wdata), .cpu_eop(cpu_eop), .cpu_rdata(cpu_rdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) % 256);
  endfunction

  function automatic logic [15:0] stat_exp(input int busy, input int cnt);
    return 16'(busy * 2048 + cnt);
  endfunction

  function automatic logic [15:0] evt_exp(input int valid, input int err, input int rdy);
    return 16'(valid * 4 + err * 2 + rdy);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sie_push(input logic [7:0] b);
    sie_stb = 1'b1; sie_wdata = b;
    @(negedge clk);
    sie_stb = 1'b0;
  endtask

  task automatic cpu_push(input logic [7:0] b);
    cpu_stb = 1'b1; cpu_wdata = b;
    @(negedge clk);
    cpu_stb = 1'b0;
  endtask

  task automatic pulse_sie_eop();
    sie_eop = 1'b1; @(negedge clk); sie_eop = 1'b0;
  endtask

  task automatic pulse_cpu_eop();
    cpu_eop = 1'b1; @(negedge clk); cpu_eop = 1'b0;
  endtask

  task automatic cpu_pop(input string req, input logic [7:0] exp);
    chk(req, {8'd0, cpu_rdata}, {8'd0, exp});
    cpu_stb = 1'b1; @(negedge clk); cpu_stb = 1'b0;
  endtask

  task automatic sie_pop(input string req, input logic [7:0] exp);
    chk(req, {8'd0, sie_rdata}, {8'd0, exp});
    sie_stb = 1'b1; @(negedge clk); sie_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk_reg("R1 status", 1'b0, 16'h0000);
    chk_reg("R1 event", 1'b1, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2/R3/R11: OUT packet length sweep 0..D+1
    for (int n = 0; n <= D + 1; n++) begin
      int kept;
      kept = (n > D) ? D : n;
      do_reset();
      for (int i = 0; i < n; i++) sie_push(pat(n, i));
      chk_reg("R2 count", 1'b0, stat_exp(0, kept));
      pulse_sie_eop();
      chk_reg("R3 count after swap", 1'b0, stat_exp(0, 0));
      chk_reg("R3 event after swap", 1'b1, evt_exp(1, 0, 1));
      chk("R3 irq", {15'd0, irq}, 16'd1);
      if (n == 0) begin
        cpu_stb = 1'b1; @(negedge clk); cpu_stb = 1'b0;
        chk_reg("R11 zero length drained", 1'b1, evt_exp(0, 0, 1));
      end else begin
        for (int i = 0; i < kept; i++) cpu_pop("R3 data", pat(n, i));
        chk_reg("R3 valid clears", 1'b1, evt_exp(0, 0, 1));
      end
      wr(1'b1, 16'h0001);
      chk("R10 irq cleared", {15'd0, irq}, 16'd0);
    end

    // R4: second packet waits while CPU bank full
    do_reset();
    for (int i = 0; i < 3; i++) sie_push(pat(10, i));
    pulse_sie_eop();
    for (int i = 0; i < 2; i++) sie_push(pat(11, i));
    pulse_sie_eop();
    chk_reg("R4 busy", 1'b0, stat_exp(1, 2));
    sie_push(8'hEE);
    chk_reg("R4 byte dropped while busy", 1'b0, stat_exp(1, 2));
    wr(1'b0, 16'h2000);
    chk_reg("R7 toggle blocked by busy", 1'b1, evt_exp(1, 1, 1));
    wr(1'b1, 16'h0003);
    chk_reg("R10 W1C both", 1'b1, evt_exp(1, 0, 0));
    chk("R10 irq low", {15'd0, irq}, 16'd0);
    for (int i = 0; i < 3; i++) cpu_pop("R4 first packet", pat(10, i));
    chk_reg("R4 swap after drain", 1'b0, stat_exp(0, 0));
    chk_reg("R4 valid after drain", 1'b1, evt_exp(1, 0, 1));
    for (int i = 0; i < 2; i++) cpu_pop("R4 second packet", pat(11, i));

    // R5: forced toggle with CPU bank empty
    do_reset();
    for (int i = 0; i < 2; i++) sie_push(pat(20, i));
    wr(1'b0, 16'h2000);
    chk_reg("R5 count after toggle", 1'b0, stat_exp(0, 0));
    chk_reg("R5 event after toggle", 1'b1, evt_exp(1, 0, 1));
    for (int i = 0; i < 2; i++) cpu_pop("R5 data", pat(20, i));

    // R6: forced toggle with unread CPU data
    do_reset();
    for (int i = 0; i < 2; i++) sie_push(pat(30, i));
    pulse_sie_eop();
    wr(1'b1, 16'h0001);
    for (int i = 0; i < 3; i++) sie_push(pat(31, i));
    wr(1'b0, 16'h2000);
    chk_reg("R6 busy after toggle", 1'b0, stat_exp(1, 3));
    chk_reg("R6 event after toggle", 1'b1, evt_exp(1, 0, 1));
    chk("R6 irq", {15'd0, irq}, 16'd1);
    for (int i = 0; i < 2; i++) cpu_pop("R6 old data kept", pat(30, i));
    chk_reg("R6 swap after drain", 1'b0, stat_exp(0, 0));
    for (int i = 0; i < 3; i++) cpu_pop("R6 toggled data", pat(31, i));

    // R7: command matrix sweep with busy clear
    for (int c = 0; c < 32; c++) begin
      int dir, cont, nak, t, k, e, legal_t;
      dir = c & 1; cont = (c >> 1) & 1; nak = (c >> 2) & 1;
      t = (c >> 3) & 1; k = (c >> 4) & 1;
      e = ((t == 1 && (dir == 1 || cont == 0)) || (k == 1 && dir == 0) ||
           ((t == 1 || k == 1) && nak == 0)) ? 1 : 0;
      legal_t = (t == 1 && e == 0) ? 1 : 0;
      do_reset();
      cfg_dir_in = 1'(dir); cfg_cont = 1'(cont); cfg_nak = 1'(nak);
      wr(1'b0, 16'(t * 8192 + k * 4096));
      chk_reg("R7 command matrix", 1'b1, evt_exp(legal_t, e, legal_t));
    end
    cfg_dir_in = 1'b0; cfg_cont = 1'b1; cfg_nak = 1'b1;

    // R8/R9: IN direction
    do_reset();
    cfg_dir_in = 1'b1;
    for (int i = 0; i < 3; i++) cpu_push(pat(40, i));
    pulse_cpu_eop();
    chk_reg("R8 count on engine side", 1'b0, stat_exp(0, 3));
    chk_reg("R8 ready", 1'b1, evt_exp(0, 0, 1));
    for (int i = 0; i < 3; i++) sie_pop("R8 tx data", pat(40, i));
    chk_reg("R8 engine bank empty", 1'b0, stat_exp(0, 0));
    for (int i = 0; i < 2; i++) cpu_push(pat(41, i));
    pulse_cpu_eop();
    chk_reg("R8 second load", 1'b0, stat_exp(0, 2));
    wr(1'b0, 16'h1000);
    chk_reg("R9 cleared", 1'b0, stat_exp(0, 0));
    chk_reg("R9 no error", 1'b1, evt_exp(0, 0, 1));
    for (int i = 0; i < 3; i++) cpu_push(pat(42, i));
    pulse_cpu_eop();
    cpu_push(pat(43, 0));
    pulse_cpu_eop();
    chk_reg("R8 busy while engine full", 1'b0, stat_exp(1, 3));
    for (int i = 0; i < 3; i++) sie_pop("R8 third packet", pat(42, i));
    chk_reg("R8 pending swapped", 1'b0, stat_exp(0, 1));
    sie_pop("R8 fourth packet", pat(43, 0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule